// File: doc/BRIEF.md
# Mode-Aware Stack Pointer Unit

This block holds the stack pointer (S) of a small 8/16-bit processor core that runs in either an emulation mode or a native mode. It forms the bank-zero address for each push and pull, applies the post-decrement and pre-increment that keep S pointing at the next free byte, and carries out the four transfers between S and the accumulator or the index register. It also packs the condition flags and the two width flags into the status byte that a push-flags operation writes.

In emulation mode the high byte of S is pinned to page one and only the low byte moves. In native mode S is a free 16-bit register anywhere in bank zero. The index width flag decides how index transfers treat the high byte. Memory, the decoder and the ALU sit outside. The decoder drives one-cycle command strobes, and the core reads the address, transfer and status outputs in the same cycle.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset S reads 0x01FF.
- R2: While emuMode is 1, S[15:8] is 0x01 after every clock edge, including the first edge after entering emulation, whatever S held before.
- R3: accToS loads all 16 bits of dataIn into S in native mode, and sToAcc drives all 16 bits of S on xferOut. The value of mFlag has no effect on either. In emulation mode accToS loads only dataIn[7:0] into the low byte.
- R4: In native mode a push decrements S by one as a 16-bit value and a pull increments it by one. Page boundaries are crossed, and the value wraps only between 0x0000 and 0xFFFF.
- R5: In emulation mode a push or pull changes only S[7:0], wrapping between 0x00 and 0xFF, so S stays within 0x0100 to 0x01FF.
- R6: idxToS in native mode with xFlag=1 loads {0x00, dataIn[7:0]}, and with xFlag=0 it loads the full dataIn.
- R7: sToIdx drives {0x00, S[7:0]} on xferOut when xFlag=1 or emuMode=1, and the full S otherwise. sToAcc takes precedence when both transfer-out strobes are set.
- R8: stackAddr has bank byte 0x00. Its low 16 bits equal the current S for a push or an idle cycle. For a pull that is taken, they equal the incremented S, the same value S will hold after the edge.
- R9: statusByte is {N,V,mFlag,xFlag,D,I,Z,C} from bit 7 down to bit 0 in native mode, with condFlags ordered {N,V,D,I,Z,C} from bit 5 down to bit 0. In emulation mode bits 5 and 4 read as 1.
- R10: When several S-changing strobes are set in one cycle, the priority is accToS, then idxToS, then push, then pull.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| emuMode | input | 1 | 1 = emulation mode, 0 = native mode |
| mFlag | input | 1 | Accumulator width flag |
| xFlag | input | 1 | Index width flag (1 = 8-bit) |
| pushReq | input | 1 | Push strobe |
| pullReq | input | 1 | Pull strobe |
| accToS | input | 1 | Transfer accumulator to S |
| sToAcc | input | 1 | Transfer S to accumulator |
| idxToS | input | 1 | Transfer index to S |
| sToIdx | input | 1 | Transfer S to index |
| dataIn | input | 16 | Accumulator or index value for a load |
| condFlags | input | 6 | {N,V,D,I,Z,C} |
| spOut | output | 16 | Current stack pointer |
| stackAddr | output | 24 | Bank-zero address of the current stack access |
| xferOut | output | 16 | Value for an S-to-register transfer |
| statusByte | output | 8 | Packed status byte for a flags push |

## Verification
S changes at the first rising edge after a strobe. stackAddr, xferOut and statusByte are combinational and are valid in the same cycle as the strobe. The bench drives inputs at the falling edge and checks the combinational outputs 1 ns later. It queues the S value the requirements predict, and a monitor compares that value 5 ns after the next rising edge, so every result is sampled away from the edge that produces it.

// File: rtl/spu_pkg.sv
package spu_pkg;
  typedef enum logic [2:0] {
    SRC_HOLD,
    SRC_FULL,
    SRC_LOWZERO,
    SRC_DEC,
    SRC_INC
  } spSrc_t;

  typedef struct packed {
    spSrc_t src;
    logic   pinPage;
    logic   readNarrow;
  } spCtrl_t;
endpackage

// File: rtl/spu_ctrl.sv
module spu_ctrl
  import spu_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    emuMode,
  input  logic    xFlag,
  input  logic    pushReq,
  input  logic    pullReq,
  input  logic    accToS,
  input  logic    sToAcc,
  input  logic    idxToS,
  input  logic    sToIdx,
  output spCtrl_t ctrl
);
  spSrc_t srcSel;

  always_comb begin
    if (accToS)                      srcSel = SRC_FULL;
    else if (idxToS)                 srcSel = (xFlag || emuMode) ? SRC_LOWZERO : SRC_FULL;
    else if (pushReq)                srcSel = SRC_DEC;
    else if (pullReq)                srcSel = SRC_INC;
    else                             srcSel = SRC_HOLD;
  end

  assign ctrl.src        = srcSel;
  assign ctrl.pinPage    = emuMode;
  assign ctrl.readNarrow = sToIdx && !sToAcc && (xFlag || emuMode);

  // R10: an accumulator load overrides every other stack command
  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    accToS |-> (ctrl.src == SRC_FULL));

  // R10: a push never yields to a simultaneous pull
  a_r10_push_over_pull: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && pullReq && !accToS && !idxToS) |-> (ctrl.src == SRC_DEC));
endmodule

// File: rtl/spu_datapath.sv
module spu_datapath
  import spu_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          BANK_W    = 8,
  parameter logic [7:0]  PAGE_ONE  = 8'h01,
  parameter logic [7:0]  RESET_LOW = 8'hFF
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  spCtrl_t                   ctrl,
  input  logic [ADDR_W-1:0]         dataIn,
  output logic [ADDR_W-1:0]         spOut,
  output logic [BANK_W+ADDR_W-1:0]  stackAddr,
  output logic [ADDR_W-1:0]         xferOut
);
  localparam int LOW_W = ADDR_W / 2;
  localparam int HI_W  = ADDR_W - LOW_W;

  logic [ADDR_W-1:0] spReg;
  logic [ADDR_W-1:0] rawNext;
  logic [ADDR_W-1:0] nextS;

  always_comb begin
    unique case (ctrl.src)
      SRC_FULL:    rawNext = dataIn;
      SRC_LOWZERO: rawNext = {{HI_W{1'b0}}, dataIn[LOW_W-1:0]};
      SRC_DEC:     rawNext = spReg - 1'b1;
      SRC_INC:     rawNext = spReg + 1'b1;
      default:     rawNext = spReg;
    endcase
  end

  assign nextS = ctrl.pinPage ? {HI_W'(PAGE_ONE), rawNext[LOW_W-1:0]} : rawNext;

  always_ff @(posedge clk) begin
    if (!rstN) spReg <= {HI_W'(PAGE_ONE), LOW_W'(RESET_LOW)};
    else       spReg <= nextS;
  end

  assign spOut     = spReg;
  assign stackAddr = {{BANK_W{1'b0}}, (ctrl.src == SRC_INC) ? nextS : spReg};
  assign xferOut   = ctrl.readNarrow ? {{HI_W{1'b0}}, spReg[LOW_W-1:0]} : spReg;

  // R2: emulation keeps the stack in page one
  a_r2_page_one: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pinPage |=> (spReg[ADDR_W-1:LOW_W] == HI_W'(PAGE_ONE)));

  // R4: native push is a plain 16-bit decrement
  a_r4_native_dec: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.src == SRC_DEC && !ctrl.pinPage) |=> (spReg == $past(spReg) - 1'b1));

  // R5: emulation pull moves only the low byte
  a_r5_emu_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.src == SRC_INC && ctrl.pinPage) |=>
      (spReg[LOW_W-1:0] == $past(spReg[LOW_W-1:0]) + 1'b1));

  // R6: narrow index load lands in zero page in native mode
  a_r6_zero_page: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.src == SRC_LOWZERO && !ctrl.pinPage) |=> (spReg[ADDR_W-1:LOW_W] == '0));
endmodule

// File: rtl/spu_status.sv
module spu_status (
  input  logic       emuMode,
  input  logic       mFlag,
  input  logic       xFlag,
  input  logic [5:0] condFlags,
  output logic [7:0] statusByte
);
  logic bit5;
  logic bit4;

  assign bit5 = emuMode ? 1'b1 : mFlag;
  assign bit4 = emuMode ? 1'b1 : xFlag;
  assign statusByte = {condFlags[5:4], bit5, bit4, condFlags[3:0]};
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import spu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      emuMode,
  input  logic                      mFlag,
  input  logic                      xFlag,
  input  logic                      pushReq,
  input  logic                      pullReq,
  input  logic                      accToS,
  input  logic                      sToAcc,
  input  logic                      idxToS,
  input  logic                      sToIdx,
  input  logic [ADDR_W-1:0]         dataIn,
  input  logic [5:0]                condFlags,
  output logic [ADDR_W-1:0]         spOut,
  output logic [BANK_W+ADDR_W-1:0]  stackAddr,
  output logic [ADDR_W-1:0]         xferOut,
  output logic [7:0]                statusByte
);
  spCtrl_t ctrl;

  spu_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .emuMode(emuMode), .xFlag(xFlag),
    .pushReq(pushReq), .pullReq(pullReq), .accToS(accToS),
    .sToAcc(sToAcc), .idxToS(idxToS), .sToIdx(sToIdx), .ctrl(ctrl)
  );

  spu_datapath #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .dataIn(dataIn),
    .spOut(spOut), .stackAddr(stackAddr), .xferOut(xferOut)
  );

  spu_status i_stat (
    .emuMode(emuMode), .mFlag(mFlag), .xFlag(xFlag),
    .condFlags(condFlags), .statusByte(statusByte)
  );
endmodule

// File: tb/test_stack_ptr_unit.sv
`timescale 1ns/1ps
module test_stack_ptr_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic emuMode = 1'b1, mFlag = 1'b1, xFlag = 1'b1;
  logic pushReq = 0, pullReq = 0, accToS = 0, sToAcc = 0, idxToS = 0, sToIdx = 0;
  logic [15:0] dataIn = '0;
  logic [5:0]  condFlags = '0;
  logic [15:0] spOut, xferOut;
  logic [23:0] stackAddr;
  logic [7:0]  statusByte;

  int tests = 0;
  int fails = 0;
  logic [15:0] mS;
  logic [15:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  stack_ptr_unit i_stack_ptr_unit (
    .clk(clk), .rstN(rstN), .emuMode(emuMode), .mFlag(mFlag), .xFlag(xFlag),
    .pushReq(pushReq), .pullReq(pullReq), .accToS(accToS), .sToAcc(sToAcc),
    .idxToS(idxToS), .sToIdx(sToIdx), .dataIn(dataIn), .condFlags(condFlags),
    .spOut(spOut), .stackAddr(stackAddr), .xferOut(xferOut), .statusByte(statusByte)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares queued S predictions after the edge that updates S
  always @(posedge clk) begin
    #5;
    if (expQ.size() > 0) begin
      logic [15:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(t, {16'h0, spOut}, {16'h0, e});
    end
  end

  task automatic doCmd(input logic emu, input logic x, input logic push, input logic pull,
                       input logic a2s, input logic i2s, input logic s2a, input logic s2i,
                       input logic [15:0] din, input string tag);
    logic [15:0] nxt;
    logic pullTaken;
    @(negedge clk);
    emuMode = emu; xFlag = x; pushReq = push; pullReq = pull;
    accToS = a2s; idxToS = i2s; sToAcc = s2a; sToIdx = s2i; dataIn = din;
    pullTaken = 1'b0;
    if (a2s)       nxt = din;
    else if (i2s)  nxt = (emu || x) ? {8'h00, din[7:0]} : din;
    else if (push) nxt = mS - 16'd1;
    else if (pull) begin nxt = mS + 16'd1; pullTaken = 1'b1; end
    else           nxt = mS;
    if (emu) nxt[15:8] = 8'h01;
    #1;
    if (pullTaken) check({tag, " R8 pull addr"}, {8'h0, stackAddr}, {8'h0, 8'h00, nxt});
    else           check({tag, " R8 addr"}, {8'h0, stackAddr}, {8'h0, 8'h00, mS});
    if (s2a)       check({tag, " R3 xfer"}, {16'h0, xferOut}, {16'h0, mS});
    else if (s2i)  check({tag, " R7 xfer"}, {16'h0, xferOut},
                         {16'h0, (emu || x) ? {8'h00, mS[7:0]} : mS});
    expQ.push_back(nxt);
    tagQ.push_back({tag, " S"});
    mS = nxt;
  endtask

  task automatic idle(input logic emu, input string tag);
    doCmd(emu, xFlag, 0, 0, 0, 0, 0, 0, 16'h0, tag);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset S", {16'h0, spOut}, 32'h01FF);
    mS = 16'h01FF;

    // R5 emulation push/pull and low-byte wrap
    doCmd(1, 1, 1, 0, 0, 0, 0, 0, 16'h0, "R5 emu push");
    doCmd(1, 1, 1, 0, 0, 0, 0, 0, 16'h0, "R5 emu push2");
    doCmd(1, 1, 0, 0, 0, 1, 0, 0, 16'hABFF, "R5 emu idx load");
    doCmd(1, 1, 0, 1, 0, 0, 0, 0, 16'h0, "R5 emu pull wrap");
    doCmd(1, 1, 1, 0, 0, 0, 0, 0, 16'h0, "R5 emu push wrap");
    doCmd(1, 1, 0, 0, 1, 0, 0, 0, 16'h7722, "R3 emu acc load");
    doCmd(1, 0, 0, 0, 0, 0, 0, 1, 16'h0, "R7 emu narrow read");

    // native mode, R3 full-width with M=1
    mFlag = 1'b1;
    idle(0, "R4 enter native");
    doCmd(0, 0, 0, 0, 1, 0, 0, 0, 16'h1FFF, "R3 acc load M1");
    doCmd(0, 0, 0, 0, 0, 0, 1, 0, 16'h0, "R3 acc read M1");
    doCmd(0, 0, 0, 1, 0, 0, 0, 0, 16'h0, "R8 native pull");
    doCmd(0, 0, 0, 0, 1, 0, 0, 0, 16'h0100, "R4 load page");
    doCmd(0, 0, 1, 0, 0, 0, 0, 0, 16'h0, "R4 cross page");
    doCmd(0, 0, 1, 0, 0, 0, 0, 0, 16'h0, "R4 push again");
    doCmd(0, 0, 0, 0, 1, 0, 0, 0, 16'h0000, "R4 load zero");
    doCmd(0, 0, 1, 0, 0, 0, 0, 0, 16'h0, "R4 wrap FFFF");
    doCmd(0, 0, 0, 1, 0, 0, 0, 0, 16'h0, "R4 wrap 0000");

    // R6 / R7 index transfers
    doCmd(0, 1, 0, 0, 0, 1, 0, 0, 16'h43FF, "R6 narrow idx load");
    doCmd(0, 0, 0, 0, 0, 1, 0, 0, 16'h12AB, "R6 wide idx load");
    doCmd(0, 1, 0, 0, 0, 0, 0, 1, 16'h0, "R7 narrow read");
    doCmd(0, 0, 0, 0, 0, 0, 0, 1, 16'h0, "R7 wide read");
    doCmd(0, 1, 0, 0, 0, 0, 1, 1, 16'h0, "R7 acc read wins");

    // R10 priority
    doCmd(0, 0, 1, 1, 1, 1, 0, 0, 16'h5555, "R10 acc wins");
    doCmd(0, 1, 1, 1, 0, 1, 0, 0, 16'h6677, "R10 idx over push");
    doCmd(0, 0, 1, 1, 0, 0, 0, 0, 16'h0, "R10 push over pull");

    // R2 entering emulation pins page one
    doCmd(0, 0, 0, 0, 1, 0, 0, 0, 16'h43FF, "R2 load high");
    idle(1, "R2 enter emu");
    idle(1, "R2 stay emu");

    // R9 status byte packing
    @(negedge clk);
    pushReq = 0; pullReq = 0; accToS = 0; idxToS = 0; sToAcc = 0; sToIdx = 0;
    emuMode = 0; mFlag = 1; xFlag = 0; condFlags = 6'b101010;
    #1 check("R9 native status", {24'h0, statusByte}, {24'h0, 8'b10101010});
    mFlag = 0; xFlag = 1; condFlags = 6'b010101;
    #1 check("R9 native status2", {24'h0, statusByte}, {24'h0, 8'b01010101});
    emuMode = 1; mFlag = 0; xFlag = 0; condFlags = 6'b000000;
    #1 check("R9 emu status", {24'h0, statusByte}, {24'h0, 8'b00110000});
    mS = {8'h01, mS[7:0]};

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule